// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings a single-data-rate SDRAM from power-on to a usable state. Once reset is released it holds the command bus in no-operation for a long, frequency-derived hold-off. It then closes every bank, performs two refresh cycles, and writes a mode word that is fixed at elaboration time. After the recovery time of the mode write has passed, it raises a ready flag. From then on the memory controller that owns the bus in normal operation can take over.

Every wait is stated in nanoseconds or microseconds and converted to clock counts from a clock-frequency parameter. Each count is rounded up so that the spacing never falls below the minimum. The mode word is assembled from separate parameters for burst length code, burst ordering, read latency and write burst behaviour. The reserved fields are forced to zero. One down counter serves the long hold-off and every per-step gap.

Top module: `sdram_powerup_seq`

## Requirements
- R1: After reset is released, the command pins carry only NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1) for at least WAIT_US*CLK_MHZ cycles. The first other command appears no later than three cycles after that count.
- R2: The first command after the hold-off is precharge-all: cs_n=0, ras_n=0, cas_n=1, we_n=0, with address bit 10 high.
- R3: An auto refresh (cs_n=0, ras_n=0, cas_n=0, we_n=1) follows the precharge exactly TRP cycles later. TRP is ceil(TRP_NS*CLK_MHZ/1000), with a minimum of 2.
- R4: A second auto refresh follows the first one exactly TRC cycles later, and the mode load follows the second one exactly TRC cycles later. TRC is ceil(TRC_NS*CLK_MHZ/1000), with a minimum of 2.
- R5: The mode load (all four command pins low) drives bank 0 and this address: burst length code on bits 2:0, interleaved ordering on bit 3, read latency (2 or 3) on bits 6:4, zeros on bits 8:7, single-location writes on bit 9, and zeros on bits 11:10.
- R6: init_done rises exactly TMRD_CYC cycles after the mode-load cycle and stays high until reset.
- R7: Every cycle that is not one of the command steps drives NOP. This includes every cycle after init_done rises.
- R8: While reset is asserted the pins carry NOP and init_done is low. A reset at any point restarts the full sequence, including the whole hold-off.
- R9: One sequence issues exactly four commands, in this order: precharge-all, refresh, refresh, mode load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BA_W | Bank select |
| sd_addr | output | ADDR_W | Address lines, carrying the A10 flag and the mode word |
| init_done | output | 1 | High once the sequence has completed |

## Verification
The bound checker watches every cycle for the following:
- no command is issued before the hold-off has elapsed;
- the precharge carries the all-banks flag;
- the mode load carries the expected word on bank 0;
- each command keeps its required distance from the one before;
- init_done never drops and never coexists with a command.

The order of the four commands, the exact gap lengths, the upper bound on the hold-off and the complete restart after a mid-sequence reset depend on whole runs. Only the bench scenarios, which time-stamp each command from the reset release, can show these.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [3:0] {
    ST_WAIT, ST_PRE, ST_GAP_RP, ST_REF1, ST_GAP_RC1,
    ST_REF2, ST_GAP_RC2, ST_LMR, ST_GAP_MRD, ST_DONE
  } init_state_t;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } sd_cmd_t;

  localparam sd_cmd_t CMD_NOP = 4'b0111;
  localparam sd_cmd_t CMD_PRE = 4'b0010;
  localparam sd_cmd_t CMD_REF = 4'b0001;
  localparam sd_cmd_t CMD_LMR = 4'b0000;

  function automatic sd_cmd_t cmd_of(init_state_t s);
    case (s)
      ST_PRE:           return CMD_PRE;
      ST_REF1, ST_REF2: return CMD_REF;
      ST_LMR:           return CMD_LMR;
      default:          return CMD_NOP;
    endcase
  endfunction

endpackage

// File: rtl/sdram_init_rst_sync.sv
module sdram_init_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
  parameter int W       = 16,
  parameter int RST_VAL = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign zero   = (cnt_q == '0);
  assign cnt_en = load || !zero;

  always_comb begin
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= W'(RST_VAL);
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
  import sdram_init_pkg::*;
#(
  parameter int W        = 16,
  parameter int TRP_CYC  = 2,
  parameter int TRC_CYC  = 7,
  parameter int TMRD_CYC = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tmr_zero,
  output logic        tmr_load,
  output logic [W-1:0] tmr_val,
  output init_state_t state
);
  localparam logic [W-1:0] LD_RP  = W'(TRP_CYC - 2);
  localparam logic [W-1:0] LD_RC  = W'(TRC_CYC - 2);
  localparam logic [W-1:0] LD_MRD = W'(TMRD_CYC - 2);

  init_state_t state_q, state_d;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state_q)
      ST_WAIT:    if (tmr_zero) state_d = ST_PRE;
      ST_PRE:     begin tmr_load = 1'b1; tmr_val = LD_RP;  state_d = ST_GAP_RP;  end
      ST_GAP_RP:  if (tmr_zero) state_d = ST_REF1;
      ST_REF1:    begin tmr_load = 1'b1; tmr_val = LD_RC;  state_d = ST_GAP_RC1; end
      ST_GAP_RC1: if (tmr_zero) state_d = ST_REF2;
      ST_REF2:    begin tmr_load = 1'b1; tmr_val = LD_RC;  state_d = ST_GAP_RC2; end
      ST_GAP_RC2: if (tmr_zero) state_d = ST_LMR;
      ST_LMR:     begin tmr_load = 1'b1; tmr_val = LD_MRD; state_d = ST_GAP_MRD; end
      ST_GAP_MRD: if (tmr_zero) state_d = ST_DONE;
      default:    state_d = ST_DONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_WAIT;
    else        state_q <= state_d;
  end

  assign state = state_q;
endmodule

// File: rtl/sdram_powerup_seq.sv
module sdram_powerup_seq
  import sdram_init_pkg::*;
#(
  parameter int         CLK_MHZ   = 100,
  parameter int         WAIT_US   = 100,
  parameter int         TRP_NS    = 20,
  parameter int         TRC_NS    = 70,
  parameter int         TMRD_CYC  = 2,
  parameter int         ADDR_W    = 12,
  parameter int         BA_W      = 2,
  parameter logic [2:0] BL_CODE   = 3'b011,
  parameter bit         BURST_ILV = 1'b0,
  parameter int         CAS_LAT   = 3,
  parameter bit         WR_SINGLE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BA_W-1:0]   sd_ba,
  output logic [ADDR_W-1:0] sd_addr,
  output logic              init_done
);
  localparam int WAIT_RAW = WAIT_US * CLK_MHZ;
  localparam int WAIT_CYC = (WAIT_RAW < 1) ? 1 : WAIT_RAW;
  localparam int TRP_RAW  = (TRP_NS * CLK_MHZ + 999) / 1000;
  localparam int TRP_CYC  = (TRP_RAW < 2) ? 2 : TRP_RAW;
  localparam int TRC_RAW  = (TRC_NS * CLK_MHZ + 999) / 1000;
  localparam int TRC_CYC  = (TRC_RAW < 2) ? 2 : TRC_RAW;
  localparam int MRD_CYC  = (TMRD_CYC < 2) ? 2 : TMRD_CYC;
  localparam int CNT_W    = $clog2(WAIT_CYC + TRC_CYC + MRD_CYC + 1);
  localparam logic [2:0] CL_CODE = (CAS_LAT == 2) ? 3'd2 : 3'd3;
  localparam logic [ADDR_W-1:0] MODE_WORD =
    ADDR_W'({2'b00, WR_SINGLE, 2'b00, CL_CODE, BURST_ILV, BL_CODE});

  logic             srst_n;
  logic             tmr_zero, tmr_load;
  logic [CNT_W-1:0] tmr_val;
  init_state_t      state;
  sd_cmd_t          cmd;

  sdram_init_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n)
  );

  sdram_init_timer #(.W(CNT_W), .RST_VAL(WAIT_CYC - 1)) u_tmr (
    .clk(clk), .rst_n(srst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  sdram_init_fsm #(
    .W(CNT_W), .TRP_CYC(TRP_CYC), .TRC_CYC(TRC_CYC), .TMRD_CYC(MRD_CYC)
  ) u_fsm (
    .clk(clk), .rst_n(srst_n), .tmr_zero(tmr_zero),
    .tmr_load(tmr_load), .tmr_val(tmr_val), .state(state)
  );

  always_comb begin
    cmd     = cmd_of(state);
    sd_addr = '0;
    if (state == ST_PRE)      sd_addr[10] = 1'b1;
    else if (state == ST_LMR) sd_addr     = MODE_WORD;
  end

  assign sd_cs_n   = cmd.cs_n;
  assign sd_ras_n  = cmd.ras_n;
  assign sd_cas_n  = cmd.cas_n;
  assign sd_we_n   = cmd.we_n;
  assign sd_ba     = '0;
  assign init_done = (state == ST_DONE);
endmodule

// File: rtl/sdram_powerup_chk.sv
module sdram_powerup_chk #(
  parameter int WAIT_CYC = 1,
  parameter int TRP_CYC  = 2,
  parameter int TRC_CYC  = 2,
  parameter int TMRD_CYC = 2,
  parameter int ADDR_W   = 12,
  parameter int BA_W     = 2,
  parameter logic [ADDR_W-1:0] MODE_WORD = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sd_cs_n,
  input logic              sd_ras_n,
  input logic              sd_cas_n,
  input logic              sd_we_n,
  input logic [BA_W-1:0]   sd_ba,
  input logic [ADDR_W-1:0] sd_addr,
  input logic              init_done
);
  localparam logic [1:0] K_NONE = 2'd0, K_PRE = 2'd1, K_REF = 2'd2, K_LMR = 2'd3;

  logic        is_nop, is_pre, is_ref, is_lmr;
  logic [31:0] nop_run;
  logic [15:0] since;
  logic [1:0]  last_k;
  logic [15:0] need;

  assign is_nop = !sd_cs_n &&  sd_ras_n &&  sd_cas_n &&  sd_we_n;
  assign is_pre = !sd_cs_n && !sd_ras_n &&  sd_cas_n && !sd_we_n;
  assign is_ref = !sd_cs_n && !sd_ras_n && !sd_cas_n &&  sd_we_n;
  assign is_lmr = !sd_cs_n && !sd_ras_n && !sd_cas_n && !sd_we_n;

  always_comb begin
    case (last_k)
      K_PRE:   need = 16'(TRP_CYC);
      K_REF:   need = 16'(TRC_CYC);
      K_LMR:   need = 16'(TMRD_CYC);
      default: need = 16'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nop_run <= '0;
      since   <= '0;
      last_k  <= K_NONE;
    end else begin
      if (is_nop && nop_run != 32'hFFFF_FFFF) nop_run <= nop_run + 32'd1;
      if (!is_nop) begin
        since <= 16'd1;
        if (is_pre)      last_k <= K_PRE;
        else if (is_ref) last_k <= K_REF;
        else if (is_lmr) last_k <= K_LMR;
      end else if (since != 16'hFFFF) begin
        since <= since + 16'd1;
      end
    end
  end

  // R1: no command before the hold-off has elapsed
  a_r1_holdoff: assert property (@(posedge clk) disable iff (!rst_n)
    !is_nop |-> nop_run >= 32'(WAIT_CYC));
  // R2: precharge always addresses all banks
  a_r2_pre_all: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |-> sd_addr[10]);
  // R3 / R4: spacing from the previous command is respected
  a_r4_gap_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_nop && last_k != K_NONE) |-> since >= need);
  // R5: mode load carries the configured word on bank 0
  a_r5_mode_word: assert property (@(posedge clk) disable iff (!rst_n)
    is_lmr |-> (sd_addr == MODE_WORD && sd_ba == '0));
  // R6: ready only after the mode-load recovery, then sticky
  a_r6_done_after_mrd: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> (last_k == K_LMR && since >= 16'(TMRD_CYC)));
  a_r6_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);
  // R7: bus is idle once ready
  a_r7_idle_when_done: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> is_nop);
  // R9: only the four legal command kinds ever appear
  a_r9_legal_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    is_nop || is_pre || is_ref || is_lmr);
endmodule

bind sdram_powerup_seq sdram_powerup_chk #(
  .WAIT_CYC(WAIT_CYC), .TRP_CYC(TRP_CYC), .TRC_CYC(TRC_CYC),
  .TMRD_CYC(MRD_CYC), .ADDR_W(ADDR_W), .BA_W(BA_W), .MODE_WORD(MODE_WORD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
  .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba),
  .sd_addr(sd_addr), .init_done(init_done)
);

// File: tb/sdram_powerup_seq_tb.sv
module sdram_powerup_seq_tb;
  localparam int CLK_MHZ = 100;
  localparam int WAIT_US = 20;
  localparam int WAIT_E  = WAIT_US * CLK_MHZ;
  localparam int TRP_E   = 2;   // ceil(20*100/1000)
  localparam int TRC_E   = 7;   // ceil(70*100/1000)
  localparam int TMRD_E  = 2;
  // R5: bit9=1, CL=2 on 6:4, interleave bit3=1, BL code 010
  localparam logic [11:0] MODE_E = 12'h22A;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, init_done;
  logic [1:0]  sd_ba;
  logic [11:0] sd_addr;
  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  sdram_powerup_seq #(
    .CLK_MHZ(CLK_MHZ), .WAIT_US(WAIT_US), .TRP_NS(20), .TRC_NS(70),
    .TMRD_CYC(2), .ADDR_W(12), .BA_W(2), .BL_CODE(3'b010),
    .BURST_ILV(1'b1), .CAS_LAT(2), .WR_SINGLE(1'b1)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba),
    .sd_addr(sd_addr), .init_done(init_done)
  );

  // -1 NOP, 1 precharge, 2 refresh, 3 mode load, 0 other
  function automatic int kind_now();
    case ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n})
      4'b0111: return -1;
      4'b0010: return 1;
      4'b0001: return 2;
      4'b0000: return 3;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 60000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic t_reset_state(input string req);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(kind_now() == -1, {req, " nop in reset"}, kind_now(), -1);
      chk(!init_done, {req, " done low in reset"}, init_done, 0);
    end
  endtask

  // runs from the reset release until ready, checking R1-R7 and R9
  task automatic t_full_sequence(input string tag);
    int idx[4];
    int knd[4];
    int n = 0, other = 0, done_at = -1, a10 = 0, ba_l = -1;
    logic [11:0] lmr_a = '0;
    @(negedge clk) rst_n = 1'b1;
    for (int i = 1; i <= WAIT_E + 200 && done_at < 0; i++) begin
      @(negedge clk);
      if (init_done) done_at = i;
      else if (kind_now() != -1) begin
        if (kind_now() == 0) other++;
        if (n < 4) begin
          idx[n] = i; knd[n] = kind_now();
          if (kind_now() == 1) a10 = sd_addr[10];
          if (kind_now() == 3) begin lmr_a = sd_addr; ba_l = sd_ba; end
        end
        n++;
      end
    end
    chk(n == 4, {tag, " R9 command count"}, n, 4);
    if (n < 4) return;
    chk(knd[0] == 1 && knd[1] == 2 && knd[2] == 2 && knd[3] == 3,
        {tag, " R9 order"}, knd[0]*1000 + knd[1]*100 + knd[2]*10 + knd[3], 1223);
    chk(other == 0, {tag, " R7 stray command"}, other, 0);
    chk(idx[0] >= WAIT_E + 1, {tag, " R1 hold-off min"}, idx[0], WAIT_E + 1);
    chk(idx[0] <= WAIT_E + 3, {tag, " R1 hold-off max"}, idx[0], WAIT_E + 3);
    chk(a10 == 1, {tag, " R2 A10 on precharge"}, a10, 1);
    chk(idx[1] - idx[0] == TRP_E, {tag, " R3 precharge gap"}, idx[1] - idx[0], TRP_E);
    chk(idx[2] - idx[1] == TRC_E, {tag, " R4 refresh gap"}, idx[2] - idx[1], TRC_E);
    chk(idx[3] - idx[2] == TRC_E, {tag, " R4 refresh-to-load gap"}, idx[3] - idx[2], TRC_E);
    chk(lmr_a == MODE_E, {tag, " R5 mode word"}, lmr_a, MODE_E);
    chk(ba_l == 0, {tag, " R5 mode bank"}, ba_l, 0);
    chk(done_at - idx[3] == TMRD_E, {tag, " R6 done delay"}, done_at - idx[3], TMRD_E);
  endtask

  task automatic t_hold_after_done();
    int bad = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (!init_done || kind_now() != -1) bad++;
    end
    chk(bad == 0, "R6 R7 done held with idle bus", bad, 0);
  endtask

  task automatic t_reset_mid_sequence();
    int seen = 0;
    @(negedge clk) rst_n = 1'b1;
    for (int i = 0; i < WAIT_E + 50 && seen == 0; i++) begin
      @(negedge clk);
      if (kind_now() == 2) seen = 1;
    end
    chk(seen == 1, "R8 reached refresh before abort", seen, 1);
    rst_n = 1'b0;
    t_reset_state("R8");
    t_full_sequence("R8 rerun");
  endtask

  initial begin
    rst_n = 1'b0;
    t_reset_state("R8 initial");
    t_full_sequence("first");
    t_hold_after_done();
    @(negedge clk) rst_n = 1'b0;
    t_reset_state("R8 after done");
    t_reset_mid_sequence();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule